// File: doc/BRIEF.md
# Serial NOR Flash Read and Erase Sequencer

This block is an SPI master that runs the bus sequences a serial NOR flash needs for three host requests: a fast read of a run of bytes, an erase of one or more 4 KiB sectors, and an erase of the whole chip. The host hands over a request through a valid/ready port: an operation code, a 24-bit address and a count field that holds the number of items minus one. Read data come back one byte at a time on a valid/ready byte port, and the host may stall that port at any time.

Each operation starts with a status poll. The poll is repeated while the device reports busy. Each erase is preceded by its own write-enable transaction. A multi-sector request is split into separate erases of consecutive sectors, and every one of them gets its own poll and write-enable. The serial clock runs in mode 0 and is derived from the system clock by a parameterised half-period count. With the defaults and a 50 MHz system clock this gives 25 MHz. Chip select returns high for at least one serial clock period between transactions.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, req_ready is 1 and rd_valid is 0.
- R2: Every accepted operation begins with a status transaction: byte 0x05, then one byte clocked in. The transaction is repeated while bit 0 of the returned status is 1, and the operation proper starts only after a status with bit 0 equal to 0.
- R3: A read (req_op = 0) is one transaction. It sends 0x0B, then req_addr[23:16], req_addr[15:8] and req_addr[7:0], then one dummy byte. It then clocks in req_cnt+1 data bytes before chip select rises.
- R4: Read bytes appear on rd_data in address order, one per rd_valid/rd_ready handshake. While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data does not change.
- R5: A sector erase (req_op = 1) sends a one-byte write-enable transaction (0x06), then a separate transaction of 0x20 followed by three address bytes. The address bytes are req_addr[23:12] shifted left by 12, so the low 12 address bits are sent as zero.
- R6: A sector erase with count field c performs c+1 erases on sectors req_addr[23:12], +1, +2 and so on. Each erase has its own status poll and write-enable.
- R7: A chip erase (req_op = 2) performs the status poll, then write-enable, then one transaction made of the single byte 0xC7.
- R8: While status or read data are clocked in, MOSI carries 0xA5.
- R9: The bus uses mode 0. sclk is 0 whenever cs_n is 1, and every transaction carries whole bytes of 8 sclk pulses.
- R10: Between two transactions, cs_n stays high for at least one sclk period (2*SCLK_HALF system clocks).
- R11: req_ready falls in the cycle after an accepted operation and returns to 1 only after the operation's last transaction has finished.
- R12: A request with req_op = 3 is accepted but causes no bus activity, and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 read, 1 sector erase, 2 chip erase, 3 no-op |
| req_addr | input | 24 | Byte address (read) or sector in bits 23:12 (erase) |
| req_cnt | input | CNT_W | Bytes to read or sectors to erase, minus one |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench runs the sequencer against a behavioural flash that decodes each transaction, keeps a write-enable latch and reports busy for a set number of polls after each erase. A design that skipped or stopped the status poll early would start a command while the model was still busy, which shows up as a missing poll in the transaction log. A design that left out or merged the write-enable would be seen by the model's latch. One read crosses a 64 KiB address boundary while the host stalls the byte port, so address order errors and any change of held data under backpressure are caught. Another case is a three-sector erase that starts at sector 0x0FF. A wrong sector increment, or address bits below bit 12 leaking into the command, would show in the logged address bytes. Separate checks cover the chip-select gap, sclk while chip select is high, and partial bytes.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int ADR_W      = 24;
  localparam int SECT_SHIFT = 12;

  localparam logic [7:0] CMD_STATUS = 8'h05;
  localparam logic [7:0] CMD_WEN    = 8'h06;
  localparam logic [7:0] CMD_FREAD  = 8'h0B;
  localparam logic [7:0] CMD_SECT   = 8'h20;
  localparam logic [7:0] CMD_CHIP   = 8'hC7;
  localparam logic [7:0] FILL_BYTE  = 8'hA5;

  localparam logic [1:0] OPC_READ = 2'd0;
  localparam logic [1:0] OPC_SECT = 2'd1;
  localparam logic [1:0] OPC_CHIP = 2'd2;
  localparam logic [1:0] OPC_NOP  = 2'd3;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_GAP, SQ_POLL, SQ_WEN, SQ_SECT, SQ_CHIP, SQ_READ
  } sq_state_e;
endpackage

// File: rtl/sfs_byte_shift.sv
module sfs_byte_shift #(
  parameter int SCLK_HALF = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx;
          mosi <= tx[7];
          bitn <= '0;
          cnt  <= '0;
          sclk <= 1'b0;
        end
      end else if (cnt == CW'(SCLK_HALF - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            mosi <= sh[6];
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  p_done_clk_low_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !sclk));
endmodule

// File: rtl/sfs_seq_ctrl.sv
module sfs_seq_ctrl
  import sfs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int GAP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [ADR_W-1:0] req_addr,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             cs_n,
  output logic             eng_start,
  output logic [7:0]       eng_tx,
  input  logic             eng_done,
  input  logic [7:0]       eng_rx,
  input  logic             eng_busy
);
  localparam int GW    = $clog2(GAP_CYC + 1);
  localparam int SEC_W = ADR_W - SECT_SHIFT;

  sq_state_e        st, nxt_q;
  logic [1:0]       op_q;
  logic [ADR_W-1:0] addr_q;
  logic [SEC_W-1:0] sec_q;
  logic [CNT_W-1:0] left_q;
  logic [2:0]       bidx;
  logic             inflight;
  logic [GW-1:0]    gcnt;
  logic [ADR_W-1:0] ers_addr;
  logic             in_txn;
  logic             data_ph;

  assign ers_addr  = {sec_q, {SECT_SHIFT{1'b0}}};
  assign in_txn    = (st == SQ_POLL) || (st == SQ_WEN) || (st == SQ_SECT) ||
                     (st == SQ_CHIP) || (st == SQ_READ);
  assign data_ph   = (st == SQ_READ) && (bidx == 3'd5);
  assign req_ready = (st == SQ_IDLE);
  assign eng_start = in_txn && !inflight && !eng_busy && (!data_ph || !rd_valid);

  always_comb begin
    eng_tx = FILL_BYTE;
    case (st)
      SQ_POLL: eng_tx = (bidx == 3'd0) ? CMD_STATUS : FILL_BYTE;
      SQ_WEN:  eng_tx = CMD_WEN;
      SQ_CHIP: eng_tx = CMD_CHIP;
      SQ_SECT: begin
        case (bidx)
          3'd0:    eng_tx = CMD_SECT;
          3'd1:    eng_tx = ers_addr[23:16];
          3'd2:    eng_tx = ers_addr[15:8];
          default: eng_tx = ers_addr[7:0];
        endcase
      end
      SQ_READ: begin
        case (bidx)
          3'd0:    eng_tx = CMD_FREAD;
          3'd1:    eng_tx = addr_q[23:16];
          3'd2:    eng_tx = addr_q[15:8];
          3'd3:    eng_tx = addr_q[7:0];
          default: eng_tx = FILL_BYTE;
        endcase
      end
      default: eng_tx = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      nxt_q    <= SQ_IDLE;
      op_q     <= OPC_READ;
      addr_q   <= '0;
      sec_q    <= '0;
      left_q   <= '0;
      bidx     <= '0;
      inflight <= 1'b0;
      gcnt     <= '0;
      cs_n     <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (req_valid && req_op != OPC_NOP) begin
            op_q     <= req_op;
            addr_q   <= req_addr;
            sec_q    <= req_addr[ADR_W-1:SECT_SHIFT];
            left_q   <= req_cnt;
            st       <= SQ_POLL;
            cs_n     <= 1'b0;
            bidx     <= '0;
            inflight <= 1'b0;
          end
        end
        SQ_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            st       <= nxt_q;
            cs_n     <= (nxt_q == SQ_IDLE);
            bidx     <= '0;
            inflight <= 1'b0;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        default: begin
          if (eng_start) inflight <= 1'b1;
          if (eng_done) begin
            inflight <= 1'b0;
            case (st)
              SQ_POLL: begin
                if (bidx == 3'd0) begin
                  bidx <= 3'd1;
                end else begin
                  cs_n <= 1'b1; st <= SQ_GAP; gcnt <= '0;
                  if (eng_rx[0])              nxt_q <= SQ_POLL;
                  else if (op_q == OPC_READ)  nxt_q <= SQ_READ;
                  else                        nxt_q <= SQ_WEN;
                end
              end
              SQ_WEN: begin
                cs_n <= 1'b1; st <= SQ_GAP; gcnt <= '0;
                nxt_q <= (op_q == OPC_SECT) ? SQ_SECT : SQ_CHIP;
              end
              SQ_SECT: begin
                if (bidx == 3'd3) begin
                  cs_n <= 1'b1; st <= SQ_GAP; gcnt <= '0;
                  if (left_q == '0) begin
                    nxt_q <= SQ_IDLE;
                  end else begin
                    left_q <= left_q - CNT_W'(1);
                    sec_q  <= sec_q + SEC_W'(1);
                    nxt_q  <= SQ_POLL;
                  end
                end else begin
                  bidx <= bidx + 3'd1;
                end
              end
              SQ_CHIP: begin
                cs_n <= 1'b1; st <= SQ_GAP; gcnt <= '0;
                nxt_q <= SQ_IDLE;
              end
              default: begin
                if (bidx != 3'd5) begin
                  bidx <= bidx + 3'd1;
                end else begin
                  rd_data  <= eng_rx;
                  rd_valid <= 1'b1;
                  if (left_q == '0) begin
                    cs_n <= 1'b1; st <= SQ_GAP; gcnt <= '0;
                    nxt_q <= SQ_IDLE;
                  end else begin
                    left_q <= left_q - CNT_W'(1);
                  end
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op != OPC_NOP) |=> !req_ready);
  p_nop_stays_ready_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == OPC_NOP) |=> req_ready);
  p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);
  p_start_selected_r3: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !cs_n);
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import sfs_pkg::*;
#(
  parameter int SCLK_HALF = 1,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [ADR_W-1:0] req_addr,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int GAP_CYC = 2 * SCLK_HALF;

  logic       eng_start, eng_done, eng_busy;
  logic [7:0] eng_tx, eng_rx;

  sfs_seq_ctrl #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_cnt(req_cnt),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cs_n(cs_n),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done),
    .eng_rx(eng_rx), .eng_busy(eng_busy)
  );

  sfs_byte_shift #(.SCLK_HALF(SCLK_HALF)) shift_i (
    .clk(clk), .rst(rst),
    .start(eng_start), .tx(eng_tx), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx(eng_rx)
  );

  p_desel_clk_low_r9: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  p_shift_selected_r3: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !cs_n);
endmodule

// File: tb/spi_flash_seq_tb_top.sv
module spi_flash_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, rd_valid, rd_ready;
  logic [1:0]  req_op;
  logic [23:0] req_addr;
  logic [15:0] req_cnt;
  logic [7:0]  rd_data;
  logic        sclk, mosi, miso, cs_n;

  always #10 clk = ~clk;

  spi_flash_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_cnt(req_cnt),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int nchk = 0, nbad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // behavioural flash
  logic [7:0] lg [0:63][0:7];
  int         lglen [0:63];
  int         ntx = 0, bit_n = 0, bi = 0, busy_left = 0, busy_set = 0;
  int         mosi_bad = 0, bad_erase = 0, frag = 0;
  bit         wel = 0, pend = 0, started = 0;
  logic [7:0] in_sh = 8'h00, out_sh = 8'hFF, nxt_out = 8'hFF, mop = 8'h00;
  logic [23:0] maddr = '0;

  assign miso = out_sh[7];

  task automatic take_byte(input logic [7:0] b);
    if (ntx < 64) begin
      if (bi < 8) lg[ntx][bi] = b;
      lglen[ntx] = bi + 1;
    end
    if (bi == 0) begin
      mop = b;
      if (b == 8'h06) wel = 1;
    end
    if (mop == 8'h05 && bi == 1 && b != 8'hA5) mosi_bad++;
    if (mop == 8'h0B && bi >= 5 && b != 8'hA5) mosi_bad++;
    if (mop == 8'h0B && bi == 1) maddr[23:16] = b;
    if (mop == 8'h0B && bi == 2) maddr[15:8] = b;
    if (mop == 8'h0B && bi == 3) maddr[7:0] = b;
    nxt_out = 8'hFF;
    if (mop == 8'h05 && bi == 0) begin
      nxt_out = (busy_left > 0) ? 8'h01 : 8'h00;
      if (busy_left > 0) busy_left--;
    end
    if (mop == 8'h0B && bi >= 4) nxt_out = dat(maddr + 24'(bi - 4));
    pend = 1;
  endtask

  always @(negedge cs_n) begin
    started = 1; bit_n = 0; bi = 0; out_sh = 8'hFF; pend = 0; mop = 8'h00;
    if (ntx < 64) lglen[ntx] = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    in_sh = {in_sh[6:0], mosi};
    bit_n++;
    if (bit_n == 8) begin
      bit_n = 0;
      take_byte(in_sh);
      bi++;
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    if (pend) begin out_sh = nxt_out; pend = 0; end
    else out_sh = {out_sh[6:0], 1'b1};
  end

  always @(posedge cs_n) if (started) begin
    if (bit_n != 0) frag++;
    if ((mop == 8'h20 && lglen[ntx] == 4) || (mop == 8'hC7 && lglen[ntx] == 1)) begin
      if (!wel) bad_erase++;
      wel = 0;
      busy_left = busy_set;
    end
    ntx++;
  end

  // bus monitors and host read port
  int  hi_cnt = 0, min_gap = 1000, sclk_desel = 0, stall_viol = 0, ngot = 0;
  bit  seen_tx = 0, prev_cs = 1, prev_stall = 0, stall_mode = 0;
  logic [7:0] prev_data = '0;
  logic [7:0] got [0:31];

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (cs_n) hi_cnt++;
      else begin
        if (prev_cs && seen_tx && hi_cnt < min_gap) min_gap = hi_cnt;
        hi_cnt = 0; seen_tx = 1;
      end
      prev_cs = cs_n;
      if (prev_stall && (!rd_valid || rd_data != prev_data)) stall_viol++;
      prev_stall = rd_valid && !rd_ready;
      prev_data  = rd_data;
      if (rd_valid && rd_ready) begin
        if (ngot < 32) got[ngot] = rd_data;
        ngot++;
      end
    end
    if (cyc == 150000) begin
      nbad++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cs_n && sclk && !rst) sclk_desel++;
    rd_ready <= stall_mode ? ((cyc % 7) == 3) : 1'b1;
  end

  task automatic issue(input logic [1:0] op, input logic [23:0] a, input logic [15:0] c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_cnt = c;
    @(negedge clk);
    req_valid = 0;
    if (op != 2'd3) chk(req_ready == 1'b0, "R11", "ready low after accept", req_ready, 0);
    else            chk(req_ready == 1'b1, "R12", "ready stays high", req_ready, 1);
    while (!req_ready) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic txn_is(input int idx, input int len, input logic [7:0] b0,
                        input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3, input string req);
    chk(lglen[idx] == len, req, $sformatf("txn %0d length", idx), lglen[idx], len);
    chk(lg[idx][0] == b0, req, $sformatf("txn %0d byte0", idx), lg[idx][0], b0);
    if (len > 1) chk(lg[idx][1] == b1, req, $sformatf("txn %0d byte1", idx), lg[idx][1], b1);
    if (len > 2) chk(lg[idx][2] == b2, req, $sformatf("txn %0d byte2", idx), lg[idx][2], b2);
    if (len > 3) chk(lg[idx][3] == b3, req, $sformatf("txn %0d byte3", idx), lg[idx][3], b3);
  endtask

  task automatic t_reset;
    chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
  endtask

  task automatic t_read_plain;
    int base = ntx;
    ngot = 0; busy_left = 0;
    issue(2'd0, 24'h123456, 16'd3);
    chk(ntx - base == 2, "R2", "txn count plain read", ntx - base, 2);
    txn_is(base, 2, 8'h05, 8'hA5, 0, 0, "R2");
    txn_is(base + 1, 9, 8'h0B, 8'h12, 8'h34, 8'h56, "R3");
    chk(lg[base + 1][4] == 8'hA5, "R3", "dummy byte", lg[base + 1][4], 8'hA5);
    chk(ngot == 4, "R4", "bytes delivered", ngot, 4);
    for (int i = 0; i < 4; i++)
      chk(got[i] == dat(24'h123456 + 24'(i)), "R4", $sformatf("data %0d", i),
          got[i], dat(24'h123456 + 24'(i)));
  endtask

  task automatic t_read_stall_busy;
    int base = ntx;
    ngot = 0; busy_left = 2; stall_mode = 1;
    issue(2'd0, 24'h00FFFE, 16'd5);
    stall_mode = 0;
    chk(ntx - base == 4, "R2", "txn count with busy polls", ntx - base, 4);
    for (int i = 0; i < 3; i++) txn_is(base + i, 2, 8'h05, 8'hA5, 0, 0, "R2");
    txn_is(base + 3, 11, 8'h0B, 8'h00, 8'hFF, 8'hFE, "R3");
    chk(ngot == 6, "R4", "bytes delivered under stall", ngot, 6);
    for (int i = 0; i < 6; i++)
      chk(got[i] == dat(24'h00FFFE + 24'(i)), "R4", $sformatf("stalled data %0d", i),
          got[i], dat(24'h00FFFE + 24'(i)));
  endtask

  task automatic t_sector_one;
    int base = ntx;
    busy_left = 0; busy_set = 0;
    issue(2'd1, 24'h123ABC, 16'd0);
    chk(ntx - base == 3, "R5", "txn count one sector", ntx - base, 3);
    txn_is(base, 2, 8'h05, 8'hA5, 0, 0, "R2");
    txn_is(base + 1, 1, 8'h06, 0, 0, 0, "R5");
    txn_is(base + 2, 4, 8'h20, 8'h12, 8'h30, 8'h00, "R5");
  endtask

  task automatic t_sector_multi;
    int base = ntx;
    busy_left = 0; busy_set = 1;
    issue(2'd1, 24'h0FF123, 16'd2);
    chk(ntx - base == 11, "R6", "txn count three sectors", ntx - base, 11);
    txn_is(base + 1, 1, 8'h06, 0, 0, 0, "R6");
    txn_is(base + 2, 4, 8'h20, 8'h0F, 8'hF0, 8'h00, "R6");
    txn_is(base + 3, 2, 8'h05, 8'hA5, 0, 0, "R6");
    txn_is(base + 4, 2, 8'h05, 8'hA5, 0, 0, "R6");
    txn_is(base + 5, 1, 8'h06, 0, 0, 0, "R6");
    txn_is(base + 6, 4, 8'h20, 8'h10, 8'h00, 8'h00, "R6");
    txn_is(base + 9, 1, 8'h06, 0, 0, 0, "R6");
    txn_is(base + 10, 4, 8'h20, 8'h10, 8'h10, 8'h00, "R6");
  endtask

  task automatic t_chip;
    int base = ntx;
    busy_set = 0;
    issue(2'd2, 24'hABCDEF, 16'd7);
    chk(ntx - base == 4, "R7", "txn count chip erase", ntx - base, 4);
    txn_is(base, 2, 8'h05, 8'hA5, 0, 0, "R7");
    txn_is(base + 1, 2, 8'h05, 8'hA5, 0, 0, "R7");
    txn_is(base + 2, 1, 8'h06, 0, 0, 0, "R7");
    txn_is(base + 3, 1, 8'hC7, 0, 0, 0, "R7");
  endtask

  task automatic t_nop;
    int base = ntx;
    issue(2'd3, 24'h000000, 16'd0);
    chk(ntx == base, "R12", "no bus activity", ntx, base);
    chk(cs_n == 1'b1, "R12", "cs_n idle", cs_n, 1);
  endtask

  initial begin
    rst = 1; req_valid = 0; req_op = 0; req_addr = 0; req_cnt = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_plain();
    t_read_stall_busy();
    t_sector_one();
    t_sector_multi();
    t_chip();
    t_nop();
    chk(mosi_bad == 0, "R8", "fill byte on MOSI", mosi_bad, 0);
    chk(min_gap >= 2, "R10", "cs high gap", min_gap, 2);
    chk(sclk_desel == 0, "R9", "sclk high while deselected", sclk_desel, 0);
    chk(frag == 0, "R9", "partial bytes", frag, 0);
    chk(stall_viol == 0, "R4", "data held under stall", stall_viol, 0);
    chk(bad_erase == 0, "R5", "erase without write enable", bad_erase, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule